// File: doc/BRIEF.md
# Configurable Asynchronous Frame Transmitter

This block turns one data word at a time into an asynchronous serial frame on a single transmit line. A word of up to nine bits, with a per-word break flag, is taken over a valid/ready handshake. The block then drives a low start bit, the data bits in the chosen order, an optional hardware-computed parity bit, and a stop interval of half, one, one-and-a-half or two bit periods. A programmable gap of zero to three bit periods can be placed before every frame. Frame timing comes from an external divider that delivers a one-cycle tick at twice the bit rate, so every bit lasts two ticks and fractional stop lengths fall on tick boundaries.

Around the framing sit the line controls. A clear-to-send input, with selectable polarity, can hold back the start of new frames. The line can be inverted, and it can be released through an output-enable whenever the transmitter has nothing to send. A one-cycle completion pulse and an idle level report the end of the last frame of a burst. Frame format and break are captured when a word is accepted, so later configuration changes affect only later words. Inversion and release act at once.

Top module: `async_frame_tx`

## Requirements
- R1: The width code selects 7 (code 1), 8 (code 2) or 9 (code 3) data bits; code 0 behaves as 8 bits. Bits of the word above the selected width are not sent.
- R2: The parity code adds a parity bit after the data: code 2 makes the count of ones over data and parity even, code 3 makes it odd, and codes 0 and 1 add no parity bit.
- R3: The stop code sets the stop interval to (code + 1) half-bit periods, that is 0.5, 1, 1.5 or 2 bit periods, with the line at the mark level (logic 1 before inversion).
- R4: A frame begins with one bit period of logic 0. With the order control clear, data bit 0 is sent first; with it set, the highest selected data bit is sent first.
- R5: A gap code g keeps the line at the mark level for 2*g half-bit ticks between acceptance of a word and its start bit, and word_ready stays low during the gap.
- R6: A word with the break flag set holds the line at logic 0 (before inversion) for the full length the frame would have had, parity and stop included, and then returns to mark.
- R7: With CTS gating enabled, word_ready stays low and no frame starts while cts_in differs from the selected active level (1 when the polarity control is set, else 0); a frame in progress always completes.
- R8: line_out equals the internal level XOR cfg_invert; while nothing is being sent, the internal level is 1.
- R9: With auto release set, line_oe is 0 whenever the transmitter is idle and 1 during gap and frame; with it clear, line_oe is always 1.
- R10: frame_done pulses for exactly one cycle, in the cycle after the last stop tick, only if no word is offered in that final cycle; tx_idle is 1 exactly when no frame or gap is in progress and word_valid is low.
- R11: A word is taken on a clock edge where word_valid and word_ready are both 1, word_ready being 1 only when idle and CTS permits; width, parity, stop, order, gap and break are captured at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| half_tick | input | 1 | One-cycle pulse at twice the bit rate |
| word_valid | input | 1 | A word is offered |
| word_ready | output | 1 | The transmitter takes the offered word at this edge |
| word_data | input | 9 | Data word, bit 0 is the least significant |
| word_brk | input | 1 | Send this word as a break frame |
| cfg_width | input | 2 | Data width code |
| cfg_parity | input | 2 | Parity code |
| cfg_stop | input | 2 | Stop length code |
| cfg_msb_first | input | 1 | Send the most significant data bit first |
| cfg_gap | input | GAP_W | Gap before each frame in bit periods |
| cfg_cts_en | input | 1 | Gate frame starts with cts_in |
| cfg_cts_active_high | input | 1 | cts_in is active when 1 |
| cts_in | input | 1 | Clear-to-send |
| cfg_invert | input | 1 | Invert the line |
| cfg_auto_release | input | 1 | Release the line while idle |
| line_out | output | 1 | Serial line |
| line_oe | output | 1 | Output enable for the line |
| tx_idle | output | 1 | Nothing in flight and nothing offered |
| frame_done | output | 1 | One-cycle completion pulse |

## Verification
Two things can land on one clock edge: the last stop tick of a frame and a word still being offered, either a second word held on the handshake or a word whose CTS permission changes right at that moment. The bench provokes this by keeping word_valid high with a fresh word while a frame runs, and by releasing or revoking CTS near the end of a frame. A behavioural queue model, fed the same inputs, predicts whether the completion pulse is suppressed and on which edge the next word is taken. It compares the line, enable, ready, idle and completion outputs with the model after every clock.

// File: rtl/txf_pkg.sv
// Shared constants and types of the asynchronous frame transmitter.
// Assumes at most nine data bits and one optional parity bit per frame.
package txf_pkg;
    localparam int MAX_DATA = 9;                 // widest data field
    localparam int FRAME_W  = MAX_DATA + 2;      // start + data + parity
    localparam int HALF_W   = 5;                 // holds up to 2*FRAME_W+4 half bits
    localparam int IDX_W    = HALF_W - 1;        // bit index inside a frame

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GAP  = 2'd1,
        ST_SEND = 2'd2
    } txf_state_e;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;    // bit k is sent during bit period k
        logic [HALF_W-1:0]  halves;  // total frame length in half-bit ticks
        logic               brk;     // send as break
    } txf_frame_t;
endpackage

// File: rtl/txf_builder.sv
// Frame builder: turns a data word and the format controls into a bit
// vector in transmit order plus the frame length in half-bit ticks.
// Purely combinational; the caller captures the result on acceptance.
module txf_builder
    import txf_pkg::*;
(
    input  logic [MAX_DATA-1:0] data,
    input  logic                brk,
    input  logic [1:0]          width_code,
    input  logic [1:0]          parity_code,
    input  logic [1:0]          stop_code,
    input  logic                msb_first,
    output txf_frame_t          frame
);
    localparam logic [3:0] FULL_W = 4'(MAX_DATA);

    logic [3:0]          nd;
    logic                par_en;
    logic                ones;
    logic [MAX_DATA-1:0] left_aligned;

    // Decode the number of data bits.
    always_comb begin
        case (width_code)
            2'd1:    nd = 4'd7;
            2'd3:    nd = 4'd9;
            default: nd = 4'd8;
        endcase
    end

    assign par_en       = parity_code[1];
    assign left_aligned = data << (FULL_W - nd);

    // Reduce the selected data bits to their parity.
    always_comb begin
        ones = 1'b0;
        for (int i = 0; i < MAX_DATA; i++) begin
            if (i < int'(nd)) ones = ones ^ data[i];
        end
    end

    // Lay out start, data, parity; unused positions stay at mark.
    always_comb begin
        frame.bits    = '1;
        frame.bits[0] = 1'b0;
        for (int i = 0; i < MAX_DATA; i++) begin
            if (i < int'(nd))
                frame.bits[i+1] = msb_first ? left_aligned[MAX_DATA-1-i] : data[i];
        end
        for (int j = 1; j < FRAME_W; j++) begin
            if (par_en && j == int'(nd) + 1)
                frame.bits[j] = parity_code[0] ? ~ones : ones;
        end
        frame.halves = HALF_W'(2 * (1 + int'(nd) + int'(par_en)) + int'(stop_code) + 1);
        frame.brk    = brk;
    end
endmodule

// File: rtl/txf_timer.sv
// Frame timer: walks through the optional gap and the captured frame,
// one step per half-bit tick, and flags the final tick of the frame.
// Assumes start is only raised while idle.
module txf_timer
    import txf_pkg::*;
#(
    parameter int GAP_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             half_tick,
    input  logic             start,
    input  txf_frame_t       frame_in,
    input  logic [GAP_W-1:0] gap_code,
    output logic             busy,
    output logic             raw_level,
    output logic             frame_end
);
    localparam int GCNT_W = GAP_W + 1;

    txf_state_e        state;
    txf_frame_t        frame_q;
    logic [HALF_W-1:0] hcnt;
    logic [GCNT_W-1:0] gcnt;
    logic [GCNT_W-1:0] gap_halves;
    logic [GCNT_W-1:0] gap_q;
    logic [IDX_W-1:0]  bit_idx;
    logic              gap_end;

    assign bit_idx   = hcnt[HALF_W-1:1];
    assign gap_end   = (state == ST_GAP) && half_tick && (gcnt == gap_q - 1'b1);
    assign frame_end = (state == ST_SEND) && half_tick && (hcnt == frame_q.halves - 1'b1);
    assign busy      = (state != ST_IDLE);
    assign gap_halves = {gap_code, 1'b0};

    // Sequence idle -> gap -> frame -> idle, counting half-bit ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            frame_q <= '0;
            hcnt    <= '0;
            gcnt    <= '0;
            gap_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        frame_q <= frame_in;
                        gap_q   <= gap_halves;
                        hcnt    <= '0;
                        gcnt    <= '0;
                        state   <= (gap_halves == '0) ? ST_SEND : ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (gap_end) begin
                        state <= ST_SEND;
                        hcnt  <= '0;
                    end else if (half_tick) begin
                        gcnt <= gcnt + 1'b1;
                    end
                end
                ST_SEND: begin
                    if (frame_end) state <= ST_IDLE;
                    else if (half_tick) hcnt <= hcnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Select the level of the current bit; mark outside the frame body.
    always_comb begin
        raw_level = 1'b1;
        if (state == ST_SEND) begin
            if (frame_q.brk)
                raw_level = 1'b0;
            else if (int'(bit_idx) < FRAME_W)
                raw_level = frame_q.bits[bit_idx];
        end
    end
endmodule

// File: rtl/txf_pin.sv
// Line driver: applies inversion and decides whether the line is driven.
// Assumes busy covers both the gap and the frame.
module txf_pin (
    input  logic raw_level,
    input  logic busy,
    input  logic invert,
    input  logic auto_release,
    output logic line_out,
    output logic line_oe
);
    // Invert the level and release it while idle when asked to.
    always_comb begin
        line_out = raw_level ^ invert;
        line_oe  = busy | ~auto_release;
    end
endmodule

// File: rtl/async_frame_tx.sv
// Asynchronous frame transmitter top: handshake, CTS gating, completion
// status, and the builder/timer/pin chain. Assumes half_tick is a one-cycle
// pulse at twice the bit rate from an external divider.
module async_frame_tx
    import txf_pkg::*;
#(
    parameter int GAP_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                half_tick,
    input  logic                word_valid,
    output logic                word_ready,
    input  logic [MAX_DATA-1:0] word_data,
    input  logic                word_brk,
    input  logic [1:0]          cfg_width,
    input  logic [1:0]          cfg_parity,
    input  logic [1:0]          cfg_stop,
    input  logic                cfg_msb_first,
    input  logic [GAP_W-1:0]    cfg_gap,
    input  logic                cfg_cts_en,
    input  logic                cfg_cts_active_high,
    input  logic                cts_in,
    input  logic                cfg_invert,
    input  logic                cfg_auto_release,
    output logic                line_out,
    output logic                line_oe,
    output logic                tx_idle,
    output logic                frame_done
);
    txf_frame_t built;
    logic       busy;
    logic       raw_level;
    logic       frame_end;
    logic       cts_ok;
    logic       accept;

    assign cts_ok     = ~cfg_cts_en | (cts_in == cfg_cts_active_high);
    assign word_ready = ~busy & cts_ok;
    assign accept     = word_valid & word_ready;
    assign tx_idle    = ~busy & ~word_valid;

    txf_builder u_builder (
        .data        (word_data),
        .brk         (word_brk),
        .width_code  (cfg_width),
        .parity_code (cfg_parity),
        .stop_code   (cfg_stop),
        .msb_first   (cfg_msb_first),
        .frame       (built)
    );

    txf_timer #(.GAP_W(GAP_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_tick (half_tick),
        .start     (accept),
        .frame_in  (built),
        .gap_code  (cfg_gap),
        .busy      (busy),
        .raw_level (raw_level),
        .frame_end (frame_end)
    );

    txf_pin u_pin (
        .raw_level    (raw_level),
        .busy         (busy),
        .invert       (cfg_invert),
        .auto_release (cfg_auto_release),
        .line_out     (line_out),
        .line_oe      (line_oe)
    );

    // Pulse completion after the last stop tick when nothing is waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_done <= 1'b0;
        else        frame_done <= frame_end & ~word_valid;
    end
endmodule

// File: rtl/txf_checker.sv
// Property checker for the asynchronous frame transmitter, bound to the top.
module txf_checker (
    input logic clk,
    input logic rst_n,
    input logic word_valid,
    input logic word_ready,
    input logic cts_in,
    input logic cfg_cts_en,
    input logic cfg_cts_active_high,
    input logic cfg_invert,
    input logic cfg_auto_release,
    input logic line_out,
    input logic line_oe,
    input logic frame_done,
    input logic busy
);
    a_r7_cts_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_cts_en && (cts_in != cfg_cts_active_high)) |-> !word_ready);

    a_r9_release_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_auto_release && !busy) |-> !line_oe);

    a_r8_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (line_out == !cfg_invert));

    a_r11_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_ready) |=> busy);

    a_r10_done_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !busy);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
endmodule

bind async_frame_tx txf_checker u_chk (
    .clk                 (clk),
    .rst_n               (rst_n),
    .word_valid          (word_valid),
    .word_ready          (word_ready),
    .cts_in              (cts_in),
    .cfg_cts_en          (cfg_cts_en),
    .cfg_cts_active_high (cfg_cts_active_high),
    .cfg_invert          (cfg_invert),
    .cfg_auto_release    (cfg_auto_release),
    .line_out            (line_out),
    .line_oe             (line_oe),
    .frame_done          (frame_done),
    .busy                (busy)
);

// File: tb/async_frame_tx_test.sv
`timescale 1ns/1ps
module async_frame_tx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       half_tick = 1'b0;
    logic       word_valid = 1'b0;
    logic [8:0] word_data = '0;
    logic       word_brk = 1'b0;
    logic [1:0] cfg_width = 2'd2;
    logic [1:0] cfg_parity = 2'd0;
    logic [1:0] cfg_stop = 2'd1;
    logic       cfg_msb_first = 1'b0;
    logic [1:0] cfg_gap = 2'd0;
    logic       cfg_cts_en = 1'b0;
    logic       cfg_cts_active_high = 1'b0;
    logic       cts_in = 1'b0;
    logic       cfg_invert = 1'b0;
    logic       cfg_auto_release = 1'b0;
    logic       word_ready, line_out, line_oe, tx_idle, frame_done;

    async_frame_tx uut (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick),
        .word_valid(word_valid), .word_ready(word_ready),
        .word_data(word_data), .word_brk(word_brk),
        .cfg_width(cfg_width), .cfg_parity(cfg_parity), .cfg_stop(cfg_stop),
        .cfg_msb_first(cfg_msb_first), .cfg_gap(cfg_gap),
        .cfg_cts_en(cfg_cts_en), .cfg_cts_active_high(cfg_cts_active_high),
        .cts_in(cts_in), .cfg_invert(cfg_invert),
        .cfg_auto_release(cfg_auto_release),
        .line_out(line_out), .line_oe(line_oe),
        .tx_idle(tx_idle), .frame_done(frame_done)
    );

    always #4 clk = ~clk;   // 125 MHz

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R10";
    int    tick_div = 3;
    int    tick_cnt = 0;
    bit    lvl_q[$];        // expected internal level per half-bit tick
    bit    m_done = 1'b0;
    int    acc_cnt = 0;
    int    dut_done_cnt = 0;
    int    m_done_cnt = 0;
    bit    finished = 1'b0;

    // Half-bit tick generator, driven away from the active edge.
    always @(negedge clk) begin
        if (tick_cnt >= tick_div - 1) begin
            tick_cnt  <= 0;
            half_tick <= 1'b1;
        end else begin
            tick_cnt  <= tick_cnt + 1;
            half_tick <= 1'b0;
        end
    end

    function automatic bit cts_ok();
        return !cfg_cts_en || (cts_in == cfg_cts_active_high);
    endfunction

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    // Queue up the expected levels of one accepted word.
    task automatic m_load(input logic [8:0] d, input bit b);
        int nd;
        bit p;
        bit lv[$];
        nd = (cfg_width == 2'd1) ? 7 : (cfg_width == 2'd3) ? 9 : 8;
        for (int k = 0; k < 2 * int'(cfg_gap); k++) lvl_q.push_back(1'b1);
        lv.push_back(1'b0);
        p = 1'b0;
        for (int i = 0; i < nd; i++) begin
            lv.push_back(cfg_msb_first ? d[nd-1-i] : d[i]);
            p ^= d[i];
        end
        if (cfg_parity == 2'd2) lv.push_back(p);
        if (cfg_parity == 2'd3) lv.push_back(!p);
        foreach (lv[i]) begin
            lvl_q.push_back(b ? 1'b0 : lv[i]);
            lvl_q.push_back(b ? 1'b0 : lv[i]);
        end
        for (int k = 0; k <= int'(cfg_stop); k++) lvl_q.push_back(b ? 1'b0 : 1'b1);
    endtask

    // Reference model step at each edge, then compare outputs 1 ns later.
    always @(posedge clk) begin
        bit e_ready, e_line, e_oe, e_idle;
        if (!rst_n) begin
            lvl_q.delete();
            m_done = 1'b0;
        end else begin
            m_done = 1'b0;
            if (lvl_q.size() == 0) begin
                if (word_valid && cts_ok()) begin
                    m_load(word_data, word_brk);
                    acc_cnt++;
                end
            end else if (half_tick) begin
                void'(lvl_q.pop_front());
                if (lvl_q.size() == 0 && !word_valid) m_done = 1'b1;
            end
        end
        if (m_done) m_done_cnt++;
        #1;
        if (frame_done) dut_done_cnt++;
        e_ready = (lvl_q.size() == 0) && cts_ok();
        e_idle  = (lvl_q.size() == 0) && !word_valid;
        e_line  = ((lvl_q.size() == 0) ? 1'b1 : lvl_q[0]) ^ cfg_invert;
        e_oe    = !cfg_auto_release || (lvl_q.size() != 0);
        if (rst_n) begin
            check(line_out == e_line, "line_out", int'(line_out), int'(e_line));
            check(line_oe == e_oe, "line_oe", int'(line_oe), int'(e_oe));
            check(word_ready == e_ready, "word_ready", int'(word_ready), int'(e_ready));
            check(tx_idle == e_idle, "tx_idle", int'(tx_idle), int'(e_idle));
            check(frame_done == m_done, "frame_done", int'(frame_done), int'(m_done));
        end
    end

    // Offer one word and wait for it to be taken; optionally keep valid high.
    task automatic send(input logic [8:0] d, input bit b, input bit keep);
        int c;
        c = acc_cnt;
        word_data  = d;
        word_brk   = b;
        word_valid = 1'b1;
        while (acc_cnt == c) @(negedge clk);
        if (!keep) word_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (lvl_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic one(input logic [8:0] d, input bit b);
        send(d, b, 1'b0);
        wait_idle();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R10";
        check(tx_idle == 1'b1, "reset tx_idle", int'(tx_idle), 1);
        check(frame_done == 1'b0, "reset frame_done", int'(frame_done), 0);
        check(line_out == 1'b1, "reset line_out", int'(line_out), 1);

        cur_req = "R1";
        for (int w = 0; w < 4; w++) begin
            cfg_width = 2'(w);
            one(9'h1A5, 1'b0);
            one(9'h0FF, 1'b0);
        end
        cfg_width = 2'd2;

        cur_req = "R2";
        for (int p = 0; p < 4; p++) begin
            cfg_parity = 2'(p);
            one(9'h013, 1'b0);
            one(9'h0C3, 1'b0);
            cfg_width = 2'd3;
            one(9'h101, 1'b0);
            cfg_width = 2'd2;
        end
        cfg_parity = 2'd0;

        cur_req = "R3";
        for (int s = 0; s < 4; s++) begin
            cfg_stop = 2'(s);
            one(9'h055, 1'b0);
            cfg_parity = 2'd3;
            one(9'h0AA, 1'b0);
            cfg_parity = 2'd0;
        end
        cfg_stop = 2'd1;

        cur_req = "R4";
        cfg_msb_first = 1'b1;
        one(9'h081, 1'b0);
        cfg_width = 2'd1;
        one(9'h041, 1'b0);
        cfg_width = 2'd3;
        one(9'h1C2, 1'b0);
        cfg_width = 2'd2;
        cfg_msb_first = 1'b0;

        cur_req = "R5";
        for (int g = 1; g < 4; g++) begin
            cfg_gap = 2'(g);
            one(9'h03C, 1'b0);
        end
        cfg_gap = 2'd0;

        cur_req = "R6";
        one(9'h0FF, 1'b1);
        cfg_parity = 2'd2;
        cfg_stop = 2'd3;
        one(9'h000, 1'b1);
        cfg_parity = 2'd0;
        cfg_stop = 2'd1;

        cur_req = "R7";
        cfg_cts_en = 1'b1;
        cfg_cts_active_high = 1'b0;
        cts_in = 1'b1;
        begin
            int c0;
            c0 = acc_cnt;
            word_data = 9'h099;
            word_valid = 1'b1;
            repeat (40) @(negedge clk);
            check(acc_cnt == c0, "words taken while CTS inactive", acc_cnt - c0, 0);
            check(line_out == 1'b1, "line held at mark", int'(line_out), 1);
            cts_in = 1'b0;
            while (acc_cnt == c0) @(negedge clk);
            repeat (10) @(negedge clk);
            cts_in = 1'b1;        // revoked mid-frame, frame must finish
            word_valid = 1'b0;
            wait_idle();
        end
        cfg_cts_active_high = 1'b1;
        cts_in = 1'b1;
        one(9'h066, 1'b0);
        cfg_cts_en = 1'b0;
        cts_in = 1'b0;

        cur_req = "R8";
        cfg_invert = 1'b1;
        one(9'h0B4, 1'b0);
        one(9'h0B4, 1'b1);
        cfg_invert = 1'b0;

        cur_req = "R9";
        cfg_auto_release = 1'b1;
        cfg_gap = 2'd2;
        one(9'h0E7, 1'b0);
        cfg_gap = 2'd0;
        cfg_auto_release = 1'b0;

        cur_req = "R10";
        begin
            int d0, m0;
            d0 = dut_done_cnt;
            m0 = m_done_cnt;
            send(9'h011, 1'b0, 1'b1);
            send(9'h022, 1'b0, 1'b1);
            send(9'h033, 1'b0, 1'b0);
            wait_idle();
            check(m_done_cnt - m0 == 1, "model pulses over a burst", m_done_cnt - m0, 1);
            check(dut_done_cnt - d0 == 1, "completion pulses over a burst", dut_done_cnt - d0, 1);
        end
        tick_div = 1;
        one(9'h05A, 1'b0);
        tick_div = 3;

        cur_req = "R11";
        send(9'h0C6, 1'b0, 1'b0);
        cfg_width = 2'd3;
        cfg_parity = 2'd3;
        cfg_stop = 2'd0;
        cfg_msb_first = 1'b1;
        cfg_gap = 2'd3;
        word_brk = 1'b1;
        wait_idle();
        word_brk = 1'b0;
        one(9'h1F0, 1'b0);
        tick_div = 5;
        for (int k = 0; k < 6; k++) one(9'($urandom), 1'b0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL %s watchdog expired actual %0d expected %0d", cur_req, 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule